// File: doc/BRIEF.md
# Multi-Mode Serial Result Output Port

This block takes each 16-bit conversion result and sends it out one bit at a time, most significant bit first. A two-bit mode input selects one of four ways of sending. In two of them the port makes its own serial clock and a low-active frame signal. In the other two, an external serial clock moves the data along. Each bit advances on a falling edge of that clock, after the edge has been synchronized into the master-clock domain.

The four modes differ in what starts a transfer and which word is sent:
- **Self-clocked**: a result-ready strobe sends the new result.
- **Free-run**: a conversion-start strobe sends the word captured at the last result-ready strobe, on the port's own clock.
- **Pipelined**: a conversion-start strobe puts that held word on the data line at once, and the external clock shifts it.
- **Burst**: a result-ready strobe sends the new result under the external clock. If that clock is high when the word arrives, the first bit waits for its next falling edge.

A coding input chooses offset binary or two's complement. The choice is taken when the word is loaded.

The control is one state machine with five states:
- **IDLE**: no transfer is running.
- **XARM**: a burst word is waiting for the first external falling edge.
- **XSHIFT**: bits advance on external falling edges.
- **ILOW**: the port's own serial clock is low.
- **IHIGH**: the port's own serial clock is high.

The transitions are:
- **load**: any mode's start event.
  - Pipelined goes to XSHIFT.
  - Burst goes to XARM if the external clock is high, otherwise to XSHIFT.
  - Self-clocked and free-run go to ILOW.
- **arm-fall**: XARM to XSHIFT on a falling edge.
- **last-fall**: XSHIFT to IDLE on the falling edge after bit 15.
- **rise**: ILOW to IHIGH when the phase time ends.
- **fall**: IHIGH to ILOW when the phase time ends, while bits remain.
- **end**: IHIGH to IDLE when the phase time ends after bit 15.

Top module: `sres_port`

## Requirements
- R1: After reset, sdata is 0, sclk_out is 0, frame_n is 1 and idle is 1.
- R2: In every mode, the 16 bits of a result leave MSB first, bit 15 down to bit 0.
- R3: When twos_comp is 1, the sent word is the result with bit 15 inverted (two's complement). When twos_comp is 0, the result is sent unchanged (offset binary).
- R4: Self-clocked mode (mode = 2'b10) starts a transfer on res_ready. sclk_out is low for 2 master clocks and then high for 2, for each bit. sdata does not change while sclk_out is high.
- R5: In the internal-clock modes, frame_n falls in the cycle after the load, which is 2 master clocks before the first rising edge of sclk_out. It stays low while sclk_out is high, and it rises 2 master clocks after the last rising edge of sclk_out.
- R6: Free-run mode (mode = 2'b11) ignores res_ready as a start, and only captures the result. A conv_start strobe then sends the captured word, using the port's own clock.
- R7: Pipelined mode (mode = 2'b00) ignores res_ready as a start. On conv_start, the MSB of the word captured at the last res_ready is on sdata in the next cycle. Each later bit appears 3 master clocks after a falling edge of ext_sclk.
- R8: Burst mode (mode = 2'b01) starts on res_ready.
  - If ext_sclk is low, the MSB is on sdata in the next cycle.
  - If ext_sclk is high, sdata keeps its previous value until the next falling edge of ext_sclk, and then shows the MSB.
- R9: After all 16 bits are sent, idle returns to 1 and sdata holds the LSB. Further ext_sclk falling edges leave sdata unchanged.
- R10: A new load during a transfer drops the unsent bits. The new word starts from its MSB.
- R11: idle is 0 whenever a transfer is active, including every cycle in which frame_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result | input | 16 | Conversion result, offset binary |
| res_ready | input | 1 | One-cycle strobe: result is valid |
| conv_start | input | 1 | One-cycle strobe: a new conversion begins |
| mode | input | 2 | 00 pipelined, 01 burst, 10 self-clocked, 11 free-run |
| twos_comp | input | 1 | 1 selects two's complement output coding |
| ext_sclk | input | 1 | External serial clock, asynchronous |
| sdata | output | 1 | Serial data |
| sclk_out | output | 1 | Serial clock produced by the port |
| frame_n | output | 1 | Low-active frame for the internal-clock modes |
| idle | output | 1 | High when no transfer is active |

## Verification
A load strobe sampled at a rising edge shows its effect at the following falling edge of the master clock. In pipelined mode and in burst mode with a low ext_sclk, that effect is the MSB on sdata. In the internal-clock modes, it is frame_n low, and the first sclk_out rise follows 2 clocks later. A falling edge of ext_sclk passes through two synchronizer flops and the shift register, so the next bit is due 3 master clocks after the edge. The bench therefore waits 6 clocks after each falling edge before it compares sdata. For the internal clock, the monitor samples sdata at each observed rise of sclk_out. It counts low and high phase lengths in cycles, and it checks frame_n exactly 1 and 2 cycles after the sixteenth rise.

// File: rtl/ser_pkg.sv
package ser_pkg;
    typedef enum logic [1:0] {
        MODE_PIPE  = 2'b00,
        MODE_BURST = 2'b01,
        MODE_SELF  = 2'b10,
        MODE_FREE  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XARM,
        ST_XSHIFT,
        ST_ILOW,
        ST_IHIGH
    } st_e;
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign fall_o  = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/ser_coder.sv
module ser_coder #(
    parameter int W = 16
) (
    input  logic [W-1:0] data_i,
    input  logic         twos_i,
    output logic [W-1:0] data_o
);
    always_comb begin
        data_o      = data_i;
        data_o[W-1] = data_i[W-1] ^ twos_i;
    end
endmodule

// File: rtl/ser_phase_timer.sv
module ser_phase_timer #(
    parameter int CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expire
);
    localparam int CW = (CLKS > 1) ? $clog2(CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS - 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (expire)       cnt <= '0;
        else if (run)          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sres_port.sv
module sres_port #(
    parameter int W          = 16,
    parameter int PHASE_CLKS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] result,
    input  logic         res_ready,
    input  logic         conv_start,
    input  logic [1:0]   mode,
    input  logic         twos_comp,
    input  logic         ext_sclk,
    output logic         sdata,
    output logic         sclk_out,
    output logic         frame_n,
    output logic         idle
);
    import ser_pkg::*;

    localparam int CNTW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(W - 1);

    mode_e         md;
    st_e           state, next_state;
    logic [W-1:0]  held_q;
    logic [W-1:0]  shreg_q;
    logic [W-1:0]  pend_q;
    logic [W-1:0]  raw_word;
    logic [W-1:0]  load_word;
    logic [CNTW-1:0] bit_q;
    logic          load_ev;
    logic          ext_lvl;
    logic          ext_fall;
    logic          ph_run;
    logic          ph_exp;
    logic          last_bit;

    assign md       = mode_e'(mode);
    assign last_bit = (bit_q == LAST_BIT);

    always_comb begin
        unique case (md)
            MODE_PIPE, MODE_FREE: begin
                load_ev  = conv_start;
                raw_word = held_q;
            end
            MODE_BURST, MODE_SELF: begin
                load_ev  = res_ready;
                raw_word = result;
            end
            default: begin
                load_ev  = 1'b0;
                raw_word = result;
            end
        endcase
    end

    ser_coder #(.W(W)) coder_i (
        .data_i (raw_word),
        .twos_i (twos_comp),
        .data_o (load_word)
    );

    ser_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_sclk),
        .level_o  (ext_lvl),
        .fall_o   (ext_fall)
    );

    assign ph_run = ((state == ST_ILOW) || (state == ST_IHIGH)) && !load_ev;

    ser_phase_timer #(.CLKS(PHASE_CLKS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_ev),
        .run     (ph_run),
        .expire  (ph_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   next_state = ST_IDLE;
            ST_XARM:   if (ext_fall) next_state = ST_XSHIFT;
            ST_XSHIFT: if (ext_fall && last_bit) next_state = ST_IDLE;
            ST_ILOW:   if (ph_exp) next_state = ST_IHIGH;
            ST_IHIGH:  if (ph_exp) next_state = last_bit ? ST_IDLE : ST_ILOW;
            default:   next_state = ST_IDLE;
        endcase
        if (load_ev) begin
            unique case (md)
                MODE_PIPE:  next_state = ST_XSHIFT;
                MODE_BURST: next_state = ext_lvl ? ST_XARM : ST_XSHIFT;
                MODE_SELF:  next_state = ST_ILOW;
                MODE_FREE:  next_state = ST_ILOW;
                default:    next_state = ST_IDLE;
            endcase
        end
    end

    // captured result for the pipelined and free-run modes
    always_ff @(posedge clk) begin
        if (!rst_n)         held_q <= '0;
        else if (res_ready) held_q <= result;
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            pend_q  <= '0;
            bit_q   <= '0;
        end else if (load_ev) begin
            bit_q <= '0;
            if (md == MODE_BURST && ext_lvl) pend_q  <= load_word;
            else                             shreg_q <= load_word;
        end else begin
            unique case (state)
                ST_XARM: begin
                    if (ext_fall) begin
                        shreg_q <= pend_q;
                        bit_q   <= '0;
                    end
                end
                ST_XSHIFT: begin
                    if (ext_fall && !last_bit) begin
                        shreg_q <= {shreg_q[W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                    end
                end
                ST_IHIGH: begin
                    if (ph_exp && !last_bit) begin
                        shreg_q <= {shreg_q[W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                    end
                end
                ST_IDLE, ST_ILOW: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        sdata    = shreg_q[W-1];
        sclk_out = (state == ST_IHIGH);
        frame_n  = !((state == ST_ILOW) || (state == ST_IHIGH));
        idle     = (state == ST_IDLE);
    end
endmodule

// File: rtl/ser_port_checker.sv
module ser_port_checker (
    input logic clk,
    input logic rst_n,
    input logic sdata,
    input logic sclk_out,
    input logic frame_n,
    input logic idle
);
    assert_frame_when_sclk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> !frame_n);

    assert_frame_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> $past(sclk_out));

    assert_high_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_out) |=> sclk_out);

    assert_high_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_out && $past(sclk_out)) |=> !sclk_out);

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> $stable(sdata));

    assert_busy_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> !idle);
endmodule

bind sres_port ser_port_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdata    (sdata),
    .sclk_out (sclk_out),
    .frame_n  (frame_n),
    .idle     (idle)
);

// File: tb/sres_port_tb_top.sv
`timescale 1ns/1ps
module sres_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] result = '0;
    logic        res_ready = 1'b0;
    logic        conv_start = 1'b0;
    logic [1:0]  mode = 2'b10;
    logic        twos_comp = 1'b0;
    logic        ext_sclk = 1'b0;
    logic        sdata, sclk_out, frame_n, idle;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R4";
    logic  expq[$];

    always #4 clk = ~clk;

    sres_port dut_i (
        .clk(clk), .rst_n(rst_n), .result(result), .res_ready(res_ready),
        .conv_start(conv_start), .mode(mode), .twos_comp(twos_comp),
        .ext_sclk(ext_sclk), .sdata(sdata), .sclk_out(sclk_out),
        .frame_n(frame_n), .idle(idle)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver side: expected bits of one word, coded as required
    task automatic push_word(input logic [15:0] w, input logic tc);
        logic [15:0] e;
        e = tc ? (w ^ 16'h8000) : w;
        for (int i = 15; i >= 0; i--) expq.push_back(e[i]);
    endtask

    task automatic pop_cmp(input string tag);
        logic b;
        if (expq.size() == 0) begin
            chk({tag, " queue empty"}, 16'(sdata), 16'hxxxx);
        end else begin
            b = expq.pop_front();
            chk(tag, 16'(sdata), 16'(b));
        end
    endtask

    task automatic pulse_ready(input logic [15:0] w);
        result = w; res_ready = 1'b1; tick(1); res_ready = 1'b0;
    endtask

    task automatic pulse_start();
        conv_start = 1'b1; tick(1); conv_start = 1'b0;
    endtask

    // one external falling edge, then compare the advanced bit
    task automatic ext_bit(input string tag);
        ext_sclk = 1'b1; tick(4);
        ext_sclk = 1'b0; tick(6);
        pop_cmp(tag);
    endtask

    // monitor for the internal clock modes
    logic prev_s = 1'b0, prev_f = 1'b1;
    int   since_ff = 0, nrise = 0, hlen = 0, tail = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_f && !frame_n) begin since_ff = 0; nrise = 0; end
            else since_ff++;
            if (tail == 2) begin chk("R5 frame high 2 after last rise", 16'(frame_n), 16'd1); tail = 0; end
            else if (tail == 1) begin chk("R5 frame low 1 after last rise", 16'(frame_n), 16'd0); tail = 2; end
            if (sclk_out && !prev_s) begin
                nrise++;
                if (nrise == 1) chk("R5 frame lead", 16'(since_ff), 16'd2);
                chk("R5 frame low at rise", 16'(frame_n), 16'd0);
                pop_cmp({cur_tag, " R2 bit at rise"});
                hlen = 1;
                if (nrise == 16) tail = 1;
            end else if (sclk_out) begin
                hlen++;
            end
            if (!sclk_out && prev_s) chk("R4 high width", 16'(hlen), 16'd2);
            prev_s = sclk_out;
            prev_f = frame_n;
        end
    end

    initial begin
        tick(200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 sdata", 16'(sdata), 16'd0);
        chk("R1 sclk_out", 16'(sclk_out), 16'd0);
        chk("R1 frame_n", 16'(frame_n), 16'd1);
        chk("R1 idle", 16'(idle), 16'd1);

        // R4 self-clocked, offset binary
        mode = 2'b10; twos_comp = 1'b0; cur_tag = "R4";
        push_word(16'hA5C3, 1'b0);
        pulse_ready(16'hA5C3);
        chk("R11 busy after load", 16'(idle), 16'd0);
        chk("R5 frame fell", 16'(frame_n), 16'd1 ^ 16'd1);
        tick(80);
        chk("R2 all bits used", 16'(expq.size()), 16'd0);
        chk("R9 idle after self", 16'(idle), 16'd1);
        chk("R9 holds LSB", 16'(sdata), 16'd1);

        // R3 two's complement in self-clocked mode
        twos_comp = 1'b1; cur_tag = "R3";
        push_word(16'h0001, 1'b1);
        pulse_ready(16'h0001);
        tick(80);
        chk("R3 all bits used", 16'(expq.size()), 16'd0);

        // R6 free-run: ready only captures, start sends
        mode = 2'b11; twos_comp = 1'b0; cur_tag = "R6";
        pulse_ready(16'h1234);
        tick(3);
        chk("R6 ready no start", 16'(idle), 16'd1);
        push_word(16'h1234, 1'b0);
        pulse_start();
        tick(80);
        chk("R6 all bits used", 16'(expq.size()), 16'd0);

        // R7 pipelined
        mode = 2'b00; twos_comp = 1'b0;
        pulse_ready(16'h9ABC);
        tick(3);
        chk("R7 ready no start", 16'(idle), 16'd1);
        push_word(16'h9ABC, 1'b0);
        pulse_start();
        pop_cmp("R7 MSB next cycle");
        for (int i = 0; i < 15; i++) ext_bit("R7 bit");
        chk("R11 busy before last fall", 16'(idle), 16'd0);
        ext_sclk = 1'b1; tick(4); ext_sclk = 1'b0; tick(6);
        chk("R9 idle after pipe", 16'(idle), 16'd1);
        chk("R9 LSB held", 16'(sdata), 16'd0);
        ext_sclk = 1'b1; tick(4); ext_sclk = 1'b0; tick(6);
        chk("R9 extra fall no effect", 16'(sdata), 16'd0);

        // R8 burst with low external clock, R3 coding
        mode = 2'b01; twos_comp = 1'b1;
        push_word(16'h7F00, 1'b1);
        pulse_ready(16'h7F00);
        pop_cmp("R8 MSB next cycle");
        for (int i = 0; i < 15; i++) ext_bit("R8 bit");
        ext_sclk = 1'b1; tick(4); ext_sclk = 1'b0; tick(6);
        chk("R9 idle after burst", 16'(idle), 16'd1);

        // R8 burst with high external clock
        twos_comp = 1'b0;
        ext_sclk = 1'b1; tick(4);
        push_word(16'h8001, 1'b0);
        pulse_ready(16'h8001);
        tick(3);
        chk("R8 old value kept while high", 16'(sdata), 16'd0);
        chk("R11 busy while armed", 16'(idle), 16'd0);
        ext_sclk = 1'b0; tick(6);
        pop_cmp("R8 MSB after fall");
        for (int i = 0; i < 15; i++) ext_bit("R8 bit high");
        ext_sclk = 1'b1; tick(4); ext_sclk = 1'b0; tick(6);
        chk("R9 idle after burst high", 16'(idle), 16'd1);
        chk("R9 LSB held high case", 16'(sdata), 16'd1);

        // R10 restart drops unsent bits
        push_word(16'hF0F0, 1'b0);
        pulse_ready(16'hF0F0);
        pop_cmp("R10 first word MSB");
        for (int i = 0; i < 4; i++) ext_bit("R10 first word bit");
        expq.delete();
        push_word(16'h0F0F, 1'b0);
        pulse_ready(16'h0F0F);
        pop_cmp("R10 restart MSB");
        for (int i = 0; i < 15; i++) ext_bit("R10 restart bit");
        ext_sclk = 1'b1; tick(4); ext_sclk = 1'b0; tick(6);
        chk("R10 idle after restart", 16'(idle), 16'd1);
        chk("R10 all bits used", 16'(expq.size()), 16'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule